// File: doc/BRIEF.md
# SHA-512 Block Compression Engine

This block performs a single SHA-512 compression step. A 512-bit chaining value and a 1024-bit message block are presented in parallel on the cycle that `start_i` is accepted. The engine runs the 80 rounds at one round per clock and adds the saved chaining value back into the working words. It then returns the updated chaining value on `cv_o` and marks it with a one-cycle `done_o` pulse. Padding, length encoding, fetching data and chaining several blocks together are the caller's job.

The message schedule lives in a 16-word buffer that rotates by one word every round. After each full pass of 16 rounds, except the last, the engine spends 16 extra cycles rewriting the buffer in place, one word per cycle in ascending order. Words that have already been refreshed feed the words computed after them. The 80 round constants are generated inside the block when it is built.

The interface is control-style. There is no back-pressure on the result: `cv_o` holds its value until the next completion, so the caller may sample it at any time after `done_o`. `busy_o` tells the caller when a new `start_i` will be taken.

Top module: `sha512_compress`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `busy_o` and `done_o` are 0 and `cv_o` is all zeros.
- R2: A `start_i` seen while idle is accepted on that clock edge. `busy_o` is 1 from the next cycle on. `done_o` is 1 exactly 145 cycles after the accepting edge: 80 round cycles, 4 x 16 schedule cycles and 1 final-add cycle. `busy_o` is 0 whenever `done_o` is 1. A `start_i` seen during the `done_o` cycle is accepted.
- R3: `done_o` is high for exactly one cycle per accepted start.
- R4: A `start_i` that arrives while `busy_o` is 1 is ignored. It changes neither the completion time nor the result.
- R5: Word k (k = 0 is the working word "a") occupies bits [511-64k -: 64] of `cv_i` and `cv_o`. Message word k occupies bits [1023-64k -: 64] of `blk_i`. After `done_o`, `cv_o` equals the standard SHA-512 compression of (`cv_i`, `blk_i`). The round constants are the first 64 fraction bits of the cube roots of the first 80 primes.
- R6: `cv_o` changes only on the edge that raises `done_o` and is held at all other times.
- R7: After rounds 15, 31, 47 and 63 the schedule is refreshed as W[j] += W[j+9] + s0(W[j+1]) + s1(W[j+14]), with indices mod 16, for j = 0..15 in ascending order. For arbitrary data the result equals the compression that uses the conventional 80-word expanded schedule.
- R8: Every addition wraps modulo 2^64. An all-ones chaining value and block give the modular result.
- R9: `cv_i` and `blk_i` are sampled only at the accepting edge. Changing them while busy has no effect on `cv_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one compression when idle |
| cv_i | input | 512 | Incoming chaining value, word 0 in the top bits |
| blk_i | input | 1024 | Message block, word 0 in the top bits |
| busy_o | output | 1 | Compression in progress |
| done_o | output | 1 | One-cycle pulse marking a new `cv_o` |
| cv_o | output | 512 | Updated chaining value, held until the next completion |

## Verification
On every cycle, the assertions check the handshake: the reset values, the 145-cycle distance from acceptance to `done_o`, the one-cycle `done_o` pulse, that a busy engine never restarts its count, and that `cv_o` holds between completions. Whether the digest is numerically right is shown only by the bench's scenarios. These are the known single-block "abc" vector, which also confirms the generated constants, random blocks compared against a model that uses the conventional 80-word schedule, an all-ones wrap case, and inputs plus extra starts toggled while the engine is busy.

// File: rtl/sha512_pkg.sv
package sha512_pkg;
  localparam int WORD_W    = 64;
  localparam int CV_WORDS  = 8;
  localparam int BLK_WORDS = 16;
  localparam int ROUNDS    = 80;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [CV_WORDS-1:0] chain_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROUND,
    ST_EXPAND,
    ST_FINAL
  } eng_state_e;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(input word_t x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic word_t big_s1(input word_t x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction

  function automatic word_t small_s0(input word_t x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction

  function automatic word_t small_s1(input word_t x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction

  function automatic word_t choose(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t majority(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  // Fraction bits of the cube root of the idx-th prime, found bit by bit.
  function automatic word_t round_const(input int idx);
    int          found;
    int          p;
    bit          is_prime;
    logic [209:0] target;
    logic [209:0] cube;
    logic [67:0]  root;
    logic [67:0]  cand;
    found = -1;
    p     = 1;
    while (found < idx) begin
      p++;
      is_prime = 1'b1;
      for (int d = 2; d * d <= p; d++) begin
        if (p % d == 0) is_prime = 1'b0;
      end
      if (is_prime) found++;
    end
    target = 210'(p) << 192;
    root   = '0;
    for (int b = 67; b >= 0; b--) begin
      cand = root | (68'(1) << b);
      cube = 210'(cand) * 210'(cand) * 210'(cand);
      if (cube <= target) root = cand;
    end
    return 64'(root);
  endfunction
endpackage

// File: rtl/sha512_kconst.sv
module sha512_kconst
  import sha512_pkg::*;
#(
  parameter int NROUNDS = ROUNDS,
  localparam int IW = $clog2(NROUNDS)
) (
  input  logic [IW-1:0] idx_i,
  output word_t         k_o
);
  word_t rom [NROUNDS];

  for (genvar i = 0; i < NROUNDS; i++) begin : g_rom
    localparam word_t KVAL = round_const(i);
    assign rom[i] = KVAL;
  end

  assign k_o = rom[idx_i];
endmodule

// File: rtl/sha512_round.sv
module sha512_round
  import sha512_pkg::*;
(
  input  chain_t st_i,
  input  word_t  k_i,
  input  word_t  w_i,
  output chain_t st_o
);
  word_t t_sum;
  word_t a_mix;

  always_comb begin
    t_sum = st_i[7] + big_s1(st_i[4]) + choose(st_i[4], st_i[5], st_i[6]) + k_i + w_i;
    a_mix = big_s0(st_i[0]) + majority(st_i[0], st_i[1], st_i[2]);
    st_o[0] = t_sum + a_mix;
    st_o[1] = st_i[0];
    st_o[2] = st_i[1];
    st_o[3] = st_i[2];
    st_o[4] = st_i[3] + t_sum;
    st_o[5] = st_i[4];
    st_o[6] = st_i[5];
    st_o[7] = st_i[6];
  end
endmodule

// File: rtl/sha512_msgbuf.sv
module sha512_msgbuf
  import sha512_pkg::*;
#(
  parameter int NW = BLK_WORDS,
  localparam int TAP_NEAR = 1,
  localparam int TAP_MID  = 9,
  localparam int TAP_FAR  = NW - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [NW*WORD_W-1:0] blk_i,
  input  logic               shift_i,
  input  logic               expand_i,
  output word_t              head_o
);
  word_t msg_q [NW];
  word_t fresh;

  // Position k holds logical index (k + steps) mod NW, so the taps are fixed.
  assign fresh  = msg_q[0] + msg_q[TAP_MID] + small_s0(msg_q[TAP_NEAR]) + small_s1(msg_q[TAP_FAR]);
  assign head_o = msg_q[0];

  for (genvar k = 0; k < NW; k++) begin : g_slot
    word_t nxt;
    if (k == NW - 1) begin : g_tail
      always_comb begin
        if (load_i)        nxt = blk_i[NW*WORD_W-1-WORD_W*k -: WORD_W];
        else if (expand_i) nxt = fresh;
        else if (shift_i)  nxt = msg_q[0];
        else               nxt = msg_q[k];
      end
    end else begin : g_body
      always_comb begin
        if (load_i)                  nxt = blk_i[NW*WORD_W-1-WORD_W*k -: WORD_W];
        else if (shift_i || expand_i) nxt = msg_q[k+1];
        else                         nxt = msg_q[k];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) msg_q[k] <= '0;
      else        msg_q[k] <= nxt;
    end
  end
endmodule

// File: rtl/sha512_compress.sv
module sha512_compress
  import sha512_pkg::*;
#(
  parameter int NROUNDS = ROUNDS,
  parameter int NMSG    = BLK_WORDS
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  logic [CV_WORDS*WORD_W-1:0]       cv_i,
  input  logic [NMSG*WORD_W-1:0]           blk_i,
  output logic                             busy_o,
  output logic                             done_o,
  output logic [CV_WORDS*WORD_W-1:0]       cv_o
);
  localparam int RW = $clog2(NROUNDS);
  localparam int SW = $clog2(NMSG);
  localparam int CVB = CV_WORDS * WORD_W;

  eng_state_e     st_q;
  logic [RW-1:0]  rnd_q;
  logic [SW-1:0]  sub_q;
  chain_t         work_q, save_q, digest_q, work_nxt, cv_in;
  word_t          k_cur, w_cur;
  logic           done_q;
  logic           accept;

  always_comb begin
    for (int k = 0; k < CV_WORDS; k++) begin
      cv_in[k] = cv_i[CVB-1-WORD_W*k -: WORD_W];
      cv_o[CVB-1-WORD_W*k -: WORD_W] = digest_q[k];
    end
  end

  assign accept = (st_q == ST_IDLE) && start_i;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;

  sha512_kconst #(.NROUNDS(NROUNDS)) u_kconst (
    .idx_i (rnd_q),
    .k_o   (k_cur)
  );

  sha512_msgbuf #(.NW(NMSG)) u_msgbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept),
    .blk_i    (blk_i),
    .shift_i  (st_q == ST_ROUND),
    .expand_i (st_q == ST_EXPAND),
    .head_o   (w_cur)
  );

  sha512_round u_round (
    .st_i (work_q),
    .k_i  (k_cur),
    .w_i  (w_cur),
    .st_o (work_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      rnd_q    <= '0;
      sub_q    <= '0;
      work_q   <= '0;
      save_q   <= '0;
      digest_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            work_q <= cv_in;
            save_q <= cv_in;
            rnd_q  <= '0;
            st_q   <= ST_ROUND;
          end
        end
        ST_ROUND: begin
          work_q <= work_nxt;
          rnd_q  <= rnd_q + 1'b1;
          if (rnd_q == RW'(NROUNDS - 1)) begin
            st_q <= ST_FINAL;
          end else if (rnd_q[SW-1:0] == SW'(NMSG - 1)) begin
            st_q  <= ST_EXPAND;
            sub_q <= '0;
          end
        end
        ST_EXPAND: begin
          sub_q <= sub_q + 1'b1;
          if (sub_q == SW'(NMSG - 1)) st_q <= ST_ROUND;
        end
        ST_FINAL: begin
          for (int k = 0; k < CV_WORDS; k++) digest_q[k] <= work_q[k] + save_q[k];
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sha512_compress_chk.sv
module sha512_compress_chk #(
  parameter int NROUNDS = 80,
  parameter int NMSG    = 16,
  parameter int CVB     = 512
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [CVB-1:0] cv_o
);
  localparam int LAT = NROUNDS + (NROUNDS / NMSG - 1) * NMSG + 1;
  localparam int CW  = $clog2(LAT + 2);

  logic [CW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lat_q <= '0;
    else if (busy_o)  lat_q <= lat_q + 1'b1;
    else if (start_i) lat_q <= '0;
  end

  // R1: values seen on the edge where reset is released
  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!busy_o && !done_o && cv_o == '0));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_q == CW'(LAT) && !busy_o));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (lat_q < CW'(LAT)));

  assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(cv_o));
endmodule

bind sha512_compress sha512_compress_chk #(
  .NROUNDS (NROUNDS),
  .NMSG    (NMSG),
  .CVB     (CVB)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .cv_o    (cv_o)
);

// File: tb/sha512_compress_bench.sv
`timescale 1ns/1ps
module sha512_compress_bench;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [511:0]  cv_i = '0;
  logic [1023:0] blk_i = '0;
  logic          busy_o, done_o;
  logic [511:0]  cv_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit cmp_en = 0;
  logic [63:0] kt [80];

  bit           m_busy = 0, m_done = 0;
  int           m_cnt = 0;
  logic [511:0] m_cv = '0, m_pend = '0;

  always #10 clk = ~clk;

  sha512_compress u_sha512_compress (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cv_i(cv_i), .blk_i(blk_i),
    .busy_o(busy_o), .done_o(done_o), .cv_o(cv_o)
  );

  function automatic logic [63:0] rr(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction
  function automatic logic [63:0] bs0(input logic [63:0] x); return rr(x,28)^rr(x,34)^rr(x,39); endfunction
  function automatic logic [63:0] bs1(input logic [63:0] x); return rr(x,14)^rr(x,18)^rr(x,41); endfunction
  function automatic logic [63:0] ss0(input logic [63:0] x); return rr(x,1)^rr(x,8)^(x>>7); endfunction
  function automatic logic [63:0] ss1(input logic [63:0] x); return rr(x,19)^rr(x,61)^(x>>6); endfunction

  // Integer Newton iteration from above for floor(cbrt(p * 2^192)).
  function automatic logic [63:0] bench_k(input int p);
    logic [255:0] n, x, y;
    n = 256'(p) << 192;
    x = 256'(1) << 68;
    while (1) begin
      y = (2 * x + n / (x * x)) / 3;
      if (y >= x) break;
      x = y;
    end
    return x[63:0];
  endfunction

  // Conventional 80-word schedule, independent of the batch rewrite.
  function automatic logic [511:0] ref_compress(input logic [511:0] cv, input logic [1023:0] blk);
    logic [63:0] w [80];
    logic [63:0] v [8];
    logic [63:0] t1, t2;
    logic [511:0] r;
    for (int t = 0; t < 16; t++) w[t] = blk[1023-64*t -: 64];
    for (int t = 16; t < 80; t++) w[t] = ss1(w[t-2]) + w[t-7] + ss0(w[t-15]) + w[t-16];
    for (int i = 0; i < 8; i++) v[i] = cv[511-64*i -: 64];
    for (int t = 0; t < 80; t++) begin
      t1 = v[7] + bs1(v[4]) + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kt[t] + w[t];
      t2 = bs0(v[0]) + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) r[511-64*i -: 64] = v[i] + cv[511-64*i -: 64];
    return r;
  endfunction

  function automatic logic [1023:0] rnd_bits();
    logic [1023:0] r;
    for (int i = 0; i < 32; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Cycle model: 145 edges from acceptance to done, starts ignored while busy.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_cv = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_cv = m_pend;
        end
      end else if (start_i) begin
        m_busy = 1; m_cnt = 145; m_pend = ref_compress(cv_i, blk_i);
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      check(busy_o === m_busy, "R2 busy vs model", 512'(busy_o), 512'(m_busy));
      check(done_o === m_done, "R3 done vs model", 512'(done_o), 512'(m_done));
      check(cv_o === m_cv, "R6 cv_o vs model", cv_o, m_cv);
    end
  end

  task automatic run_one(input logic [511:0] cv, input logic [1023:0] blk, input bit wiggle,
                         output logic [511:0] res);
    int n;
    @(negedge clk);
    start_i = 1; cv_i = cv; blk_i = blk;
    @(negedge clk);
    start_i = 0;
    n = 0;
    while (!done_o && n < 400) begin
      if (wiggle) begin
        cv_i = rnd_bits()[511:0];
        blk_i = rnd_bits();
        start_i = (n % 37 == 5);
      end
      @(negedge clk);
      n++;
    end
    start_i = 0;
    res = cv_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R2 watchdog act=%h exp=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int primes [80];
    int c;
    logic [511:0] h0, dig, cv, res;
    logic [1023:0] blk;
    c = 0;
    for (int q = 2; c < 80; q++) begin
      bit ok;
      ok = 1;
      for (int j = 0; j < c; j++) if (q % primes[j] == 0) ok = 0;
      if (ok) begin primes[c] = q; c++; end
    end
    for (int i = 0; i < 80; i++) kt[i] = bench_k(primes[i]);

    repeat (4) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0, "R1 flags in reset", 512'({busy_o, done_o}), 512'(0));
    check(cv_o === '0, "R1 cv_o in reset", cv_o, '0);
    rst_n = 1;
    cmp_en = 1;
    @(negedge clk);
    check(cv_o === '0 && busy_o === 1'b0, "R1 after release", cv_o, '0);

    // R5: known single-block vector
    h0 = {64'h6a09e667f3bcc908, 64'hbb67ae8584caa73b, 64'h3c6ef372fe94f82b, 64'ha54ff53a5f1d36f1,
          64'h510e527fade682d1, 64'h9b05688c2b3e6c1f, 64'h1f83d9abfb41bd6b, 64'h5be0cd19137e2179};
    dig = {64'hddaf35a193617aba, 64'hcc417349ae204131, 64'h12e6fa4e89a97ea2, 64'h0a9eeee64b55d39a,
           64'h2192992a274fc1a8, 64'h36ba3c23a3feebbd, 64'h454d4423643ce80e, 64'h2a9ac94fa54ca49f};
    blk = '0;
    blk[1023:960] = 64'h6162638000000000;
    blk[63:0] = 64'h18;
    run_one(h0, blk, 0, res);
    check(res === dig, "R5 abc digest", res, dig);

    // R8: wrap-around with all ones
    run_one({512{1'b1}}, {1024{1'b1}}, 0, res);
    check(res === ref_compress({512{1'b1}}, {1024{1'b1}}), "R8 wrap", res,
          ref_compress({512{1'b1}}, {1024{1'b1}}));

    // R9 and R4: inputs and extra starts toggled while busy
    cv = rnd_bits()[511:0];
    blk = rnd_bits();
    run_one(cv, blk, 1, res);
    check(res === ref_compress(cv, blk), "R9 R4 inputs ignored while busy", res, ref_compress(cv, blk));

    // R7: random blocks against the 80-word schedule
    for (int r = 0; r < 3; r++) begin
      cv = rnd_bits()[511:0];
      blk = rnd_bits();
      run_one(cv, blk, 0, res);
      check(res === ref_compress(cv, blk), "R7 random block", res, ref_compress(cv, blk));
    end

    // R2: start held high, taken again in the done cycle
    cv = rnd_bits()[511:0];
    blk = rnd_bits();
    @(negedge clk);
    start_i = 1; cv_i = cv; blk_i = blk;
    for (int n = 0; n < 400 && !done_o; n++) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b1, "R2 done without busy", 512'({busy_o, done_o}), 512'(1));
    @(negedge clk);
    start_i = 0;
    check(busy_o === 1'b1, "R2 restart after done", 512'(busy_o), 512'(1));
    for (int n = 0; n < 400 && !done_o; n++) @(negedge clk);
    check(cv_o === ref_compress(cv, blk), "R7 back-to-back result", cv_o, ref_compress(cv, blk));
    repeat (3) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule